// File: doc/BRIEF.md
# Firmware Upload Unlock Sequencer

This block guards the entry into a firmware upload mode that software drives over a simple register bus. After reset it lets a hold-off interval run out, sized from the clock frequency, and only then raises a ready status bit. Until that bit is set, every access to the start register is ignored.

Once ready, the block looks for an unlock pattern: three writes to the start address with no other access in between. Idle bus cycles may sit between those writes. A read, or a write to any other address, breaks the pattern. On the third write the block enters the upload state. Each write to the data address then passes one byte out as a one-cycle strobe with its data, and the block counts the bytes. When the fixed image length is reached, the block clears the active bit and sets the done bit. Software can unlock again after that to run a fresh upload. Storing the image belongs to the logic downstream.

Top module: `fw_unlock_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, the outputs ready_o, active_o, done_o and byte_vld_o are all 0. Reset is synchronous and active high.
- R2: ready_o becomes 1 after exactly HOLD_CYC = CLK_KHZ*HOLDOFF_US/1000 rising clock edges with reset low. It is 0 after HOLD_CYC-1 such edges, and it stays 1 until the next reset.
- R3: Writes to START_ADDR made while ready_o is 0 are ignored. They do not set active_o and do not count toward the unlock pattern.
- R4: When ready_o is 1 and no upload is running, three writes to START_ADDR set active_o at the edge that samples the third write and clear done_o. Cycles with neither strobe high may lie between those writes.
- R5: A read of any address, or a write to an address other than START_ADDR, between unlock writes sends the pattern count back to zero.
- R6: A read in the same cycle as a START_ADDR write breaks the pattern, and that write counts as the first of a new pattern.
- R7: While active_o is 1, each write to DATA_ADDR raises byte_vld_o for exactly the next cycle, with byte_data_o equal to the written data.
- R8: While active_o is 1, reads and writes to any address other than DATA_ADDR produce no byte strobe and do not advance the byte count.
- R9: The edge that accepts data byte number IMAGE_BYTES (default 7600) sets done_o and clears active_o. That final byte is still strobed out.
- R10: After done_o is set, writes to DATA_ADDR produce no strobe. A new unlock pattern starts a fresh upload of IMAGE_BYTES bytes.
- R11: active_o and done_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Register address of the current access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| ready_o | output | 1 | Hold-off has elapsed and unlock is allowed |
| active_o | output | 1 | Upload in progress |
| done_o | output | 1 | Last byte of the image accepted |
| byte_vld_o | output | 1 | One-cycle strobe for an accepted byte |
| byte_data_o | output | DATA_W | Accepted byte value |

## Verification
The hardest case to reach from the ports is a broken pattern that lands on a start write: a read and a start-register write in the same cycle, placed after two good writes. The stimulus issues exactly that combined access and then only two more start writes. The upload must begin only if the combined write counted as the first of the new pattern. Reaching the completion edge also takes a full image of data writes, with rejected reads and foreign writes mixed in. Those rejected accesses must leave the byte count unchanged, or the done bit arrives one byte early or late.

// File: rtl/fw_unlock_pkg.sv
package fw_unlock_pkg;

    // Loader state
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_BUSY = 2'd1,
        LD_DONE = 2'd2
    } ld_state_e;

    // Classified bus access of one cycle
    typedef struct packed {
        logic start_wr;  // write to the start register
        logic data_wr;   // write to the data register
        logic breaker;   // read, or write to a non-start address
    } bus_evt_t;

    localparam int unsigned UNLOCK_WRITES = 3;

    function automatic int unsigned holdoff_cycles(input int unsigned khz,
                                                   input int unsigned usec);
        int unsigned c;
        c = (khz * usec) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fw_bus_decode.sv
module fw_bus_decode
    import fw_unlock_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] START_ADDR = 'h3A,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h3B
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output bus_evt_t          evt_o
);
    logic is_start;
    logic is_data;

    always_comb begin
        is_start        = (addr_i == START_ADDR);
        is_data         = (addr_i == DATA_ADDR);
        evt_o.start_wr  = wr_i && is_start;
        evt_o.data_wr   = wr_i && is_data;
        evt_o.breaker   = rd_i || (wr_i && !is_start);
    end
endmodule

// File: rtl/fw_holdoff.sv
module fw_holdoff #(
    parameter int unsigned HOLD_CYC = 750000
) (
    input  logic clk,
    input  logic rst,
    output logic ready_o
);
    localparam int unsigned CNT_W = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ready_o <= 1'b0;
        end else if (!ready_o) begin
            if (cnt_q == LAST) begin
                ready_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> ready_o);
endmodule

// File: rtl/fw_unlock_detect.sv
module fw_unlock_detect
    import fw_unlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     arm_i,
    input  bus_evt_t evt_i,
    output logic     unlock_o
);
    localparam int unsigned SEQ_W = $clog2(UNLOCK_WRITES + 1);
    localparam logic [SEQ_W-1:0] SEQ_LAST = SEQ_W'(UNLOCK_WRITES - 1);

    logic [SEQ_W-1:0] seq_q;
    logic [SEQ_W-1:0] seq_d;

    always_comb begin
        seq_d    = seq_q;
        unlock_o = 1'b0;
        if (!arm_i) begin
            seq_d = '0;
        end else if (evt_i.breaker) begin
            // broken pattern; a start write in this cycle opens a new one
            seq_d = evt_i.start_wr ? SEQ_W'(1) : '0;
        end else if (evt_i.start_wr) begin
            if (seq_q == SEQ_LAST) begin
                unlock_o = 1'b1;
                seq_d    = '0;
            end else begin
                seq_d = seq_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) seq_q <= '0;
        else     seq_q <= seq_d;
    end

    assert_break_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (arm_i && evt_i.breaker && !evt_i.start_wr) |=> (seq_q == '0));
    assert_break_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (arm_i && evt_i.breaker && evt_i.start_wr) |=> (seq_q == SEQ_W'(1)));
    assert_disarmed_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !arm_i |-> !unlock_o);
endmodule

// File: rtl/fw_byte_loader.sv
module fw_byte_loader
    import fw_unlock_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned IMAGE_BYTES = 7600
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              unlock_i,
    input  bus_evt_t          evt_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              active_o,
    output logic              done_o,
    output logic              byte_vld_o,
    output logic [DATA_W-1:0] byte_data_o
);
    localparam int unsigned CNT_W = $clog2(IMAGE_BYTES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IMAGE_BYTES - 1);

    ld_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take     = (state_q == LD_BUSY) && evt_i.data_wr;
    assign active_o = (state_q == LD_BUSY);
    assign done_o   = (state_q == LD_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= LD_IDLE;
            cnt_q       <= '0;
            byte_vld_o  <= 1'b0;
            byte_data_o <= '0;
        end else begin
            byte_vld_o <= take;
            if (take) byte_data_o <= wdata_i;
            case (state_q)
                LD_IDLE, LD_DONE: begin
                    if (unlock_i) begin
                        state_q <= LD_BUSY;
                        cnt_q   <= '0;
                    end
                end
                LD_BUSY: begin
                    if (take) begin
                        if (cnt_q == LAST) begin
                            state_q <= LD_DONE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: state_q <= LD_IDLE;
            endcase
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);
    assert_strobe_data_R7: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |-> (byte_data_o == $past(wdata_i)));
    assert_done_exit_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($fell(active_o) && byte_vld_o));
endmodule

// File: rtl/fw_unlock_seq.sv
module fw_unlock_seq
    import fw_unlock_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned CLK_KHZ     = 250000,
    parameter int unsigned HOLDOFF_US  = 3000,
    parameter int unsigned IMAGE_BYTES = 7600,
    parameter logic [ADDR_W-1:0] START_ADDR = 'h3A,
    parameter logic [ADDR_W-1:0] DATA_ADDR  = 'h3B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ready_o,
    output logic              active_o,
    output logic              done_o,
    output logic              byte_vld_o,
    output logic [DATA_W-1:0] byte_data_o
);
    localparam int unsigned HOLD_CYC = holdoff_cycles(CLK_KHZ, HOLDOFF_US);

    bus_evt_t evt;
    logic     unlock;
    logic     arm;

    fw_bus_decode #(
        .ADDR_W    (ADDR_W),
        .START_ADDR(START_ADDR),
        .DATA_ADDR (DATA_ADDR)
    ) u_decode (
        .addr_i(bus_addr),
        .wr_i  (bus_wr),
        .rd_i  (bus_rd),
        .evt_o (evt)
    );

    fw_holdoff #(
        .HOLD_CYC(HOLD_CYC)
    ) u_holdoff (
        .clk    (clk),
        .rst    (rst),
        .ready_o(ready_o)
    );

    assign arm = ready_o && !active_o;

    fw_unlock_detect u_detect (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (arm),
        .evt_i   (evt),
        .unlock_o(unlock)
    );

    fw_byte_loader #(
        .DATA_W     (DATA_W),
        .IMAGE_BYTES(IMAGE_BYTES)
    ) u_loader (
        .clk        (clk),
        .rst        (rst),
        .unlock_i   (unlock),
        .evt_i      (evt),
        .wdata_i    (bus_wdata),
        .active_o   (active_o),
        .done_o     (done_o),
        .byte_vld_o (byte_vld_o),
        .byte_data_o(byte_data_o)
    );

    assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(active_o && done_o));
    assert_active_after_ready_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(active_o) |-> $past(ready_o));
endmodule

// File: tb/fw_unlock_seq_tb.sv
module fw_unlock_seq_tb;
    localparam int unsigned AW = 8;
    localparam int unsigned DW = 8;
    localparam int unsigned KHZ = 250000;
    localparam int unsigned US = 1;
    localparam int HOLD = 250;          // KHZ*US/1000
    localparam int NB = 7600;
    localparam logic [AW-1:0] SA = 8'h3A;
    localparam logic [AW-1:0] DA = 8'h3B;
    localparam logic [AW-1:0] OA = 8'h10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic bus_wr = 1'b0;
    logic bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic ready_o, active_o, done_o, byte_vld_o;
    logic [DW-1:0] byte_data_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    fw_unlock_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .HOLDOFF_US(US),
        .IMAGE_BYTES(NB), .START_ADDR(SA), .DATA_ADDR(DA)
    ) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ready_o(ready_o),
        .active_o(active_o), .done_o(done_o), .byte_vld_o(byte_vld_o),
        .byte_data_o(byte_data_o)
    );

    // behavioural reference model
    int m_hold = 0;
    int m_seq = 0;
    int m_bytes = 0;
    bit m_ready = 0, m_active = 0, m_done = 0, m_vld = 0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_hold = 0; m_seq = 0; m_bytes = 0;
            m_ready = 0; m_active = 0; m_done = 0; m_vld = 0; m_data = '0;
        end else begin
            bit st, brk, go;
            st  = bus_wr && (bus_addr == SA);
            brk = bus_rd || (bus_wr && bus_addr != SA);
            go  = 0;
            m_vld = 0;
            if (m_active) begin
                if (bus_wr && bus_addr == DA) begin
                    m_vld = 1; m_data = bus_wdata; m_bytes++;
                    if (m_bytes == NB) begin m_active = 0; m_done = 1; end
                end
                m_seq = 0;
            end else if (m_ready) begin
                if (brk) m_seq = st ? 1 : 0;
                else if (st) begin
                    m_seq++;
                    if (m_seq == 3) begin go = 1; m_seq = 0; end
                end
                if (go) begin m_active = 1; m_done = 0; m_bytes = 0; end
            end else begin
                m_seq = 0;
            end
            if (!m_ready) begin
                m_hold++;
                if (m_hold >= HOLD) m_ready = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk(ready_o == m_ready, "R2 ready", int'(ready_o), int'(m_ready));
            chk(active_o == m_active, "R4 active", int'(active_o), int'(m_active));
            chk(done_o == m_done, "R9 done", int'(done_o), int'(m_done));
            chk(byte_vld_o == m_vld, "R7 strobe", int'(byte_vld_o), int'(m_vld));
            if (m_vld)
                chk(byte_data_o == m_data, "R7 data", int'(byte_data_o), int'(m_data));
            chk(!(active_o && done_o), "R11 exclusive", int'(done_o), 0);
        end
    end

    task automatic cyc(input bit w, input bit r, input logic [AW-1:0] a,
                       input logic [DW-1:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, '0);
    endtask

    task automatic upload(input int seed);
        for (int i = 0; i < NB; i++) begin
            if (i == NB - 1) begin
                chk(active_o && !done_o, "R9 before last", int'(done_o), 0);
            end
            if (i % 997 == 5) cyc(1, 0, OA, 8'hEE);
            if (i % 1301 == 7) cyc(0, 1, DA, '0);
            cyc(1, 0, DA, DW'(i * 7 + seed));
        end
        chk(done_o && !active_o, "R9 after last", int'(done_o), 1);
    endtask

    initial begin
        @(negedge clk);
        chk(!ready_o && !active_o && !done_o && !byte_vld_o, "R1 in reset",
            int'(ready_o), 0);
        idle(2);
        rst = 0;
        @(negedge clk);
        chk(!ready_o && !active_o && !done_o && !byte_vld_o, "R1 after release",
            int'(active_o), 0);
        // edges since release: 1
        cyc(1, 0, SA, 8'h01); cyc(1, 0, SA, 8'h02); cyc(1, 0, SA, 8'h03);
        chk(!active_o, "R3 early start ignored", int'(active_o), 0);
        idle(HOLD - 5);                         // edges: HOLD-1
        chk(!ready_o, "R2 not yet ready", int'(ready_o), 0);
        idle(1);                                // edges: HOLD
        chk(ready_o, "R2 ready", int'(ready_o), 1);
        // R5: read breaks
        cyc(1, 0, SA, 0); cyc(1, 0, SA, 0); cyc(0, 1, OA, 0); cyc(1, 0, SA, 0);
        chk(!active_o, "R5 read breaks", int'(active_o), 0);
        cyc(0, 1, SA, 0);
        cyc(1, 0, SA, 0); cyc(1, 0, SA, 0); cyc(1, 0, OA, 0); cyc(1, 0, SA, 0);
        chk(!active_o, "R5 foreign write breaks", int'(active_o), 0);
        cyc(0, 1, SA, 0);
        // R6: read with start write restarts at one
        cyc(1, 0, SA, 0); cyc(1, 0, SA, 0); cyc(1, 1, SA, 0);
        chk(!active_o, "R6 combined no unlock", int'(active_o), 0);
        cyc(1, 0, SA, 0);
        chk(!active_o, "R6 second write", int'(active_o), 0);
        cyc(1, 0, SA, 0);
        chk(active_o, "R6 third write unlocks", int'(active_o), 1);
        // R8: ignored accesses while active
        cyc(0, 1, DA, 0);
        chk(!byte_vld_o, "R8 read no strobe", int'(byte_vld_o), 0);
        cyc(1, 0, OA, 8'h55);
        chk(!byte_vld_o, "R8 foreign write no strobe", int'(byte_vld_o), 0);
        cyc(1, 0, SA, 8'h66);
        chk(!byte_vld_o && active_o, "R8 start write no strobe", int'(byte_vld_o), 0);
        cyc(1, 0, DA, 8'hA5);
        chk(byte_vld_o && byte_data_o == 8'hA5, "R7 first byte", int'(byte_data_o), 'hA5);
        // remaining bytes of the first image (one already sent)
        for (int i = 1; i < NB; i++) cyc(1, 0, DA, DW'(i * 3));
        chk(done_o && !active_o, "R9 done after image", int'(active_o), 0);
        // R10
        cyc(1, 0, DA, 8'h11);
        chk(!byte_vld_o, "R10 no strobe after done", int'(byte_vld_o), 0);
        cyc(1, 0, SA, 0); idle(3); cyc(1, 0, SA, 0); idle(1); cyc(1, 0, SA, 0);
        chk(active_o && !done_o, "R10 R4 reunlock with gaps", int'(active_o), 1);
        upload(9);
        idle(3);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule